// File: doc/BRIEF.md
# Memory Boundary-Scan Test Access Port

This block is the serial test port of a memory device. It runs the standard sixteen-state test controller from a test clock and a mode input. It holds a three-bit instruction register, a one-bit bypass stage, a 32-bit identity word and a 107-cell boundary chain. The chain is modelled as a generic capture, shift and update structure.

The pads themselves sit outside the block. Their sampled levels arrive on `pin_in`, and the values the chain would drive leave on `pin_out`. Two control pins come from the decoded instruction. `data_hiz` asks the pad ring to float the data outputs. `extest_sel` steers the pads from the chain rather than from the functional path.

The port has no test-reset pin. A power-on reset from the device supply monitor starts it in the reset state. The pad pull-ups are outside this block and make an undriven mode or data input read as 1, so an untouched port stays in reset. The serial output `tdo` has a companion enable `tdo_oe`. When the enable is low, the pad is high impedance. All pins are plain level signals with no handshake, so back-pressure does not arise.

Top module: `scan_tap`

## Requirements
- R1: While `por_n` is low, the controller is held in Test-Logic-Reset and the active instruction is IDCODE (001). In this state `tdo_oe`, `data_hiz` and `extest_sel` are 0 and `pin_out` is all zeros.
- R2: Five consecutive rising TCK edges with TMS = 1 bring the controller to Test-Logic-Reset from any state. The active instruction is then IDCODE.
- R3: State changes follow the standard sixteen-state graph on each rising TCK edge. Both pause states hold while TMS = 0.
- R4: Capture-IR loads 3'b001 into the instruction shift stage. Shift-IR moves that stage out LSB first on `tdo`, with TDI entering at the MSB.
- R5: The opcode map is fixed as follows: 000 EXTEST, 001 IDCODE, 010 SAMPLE-Z, 100 SAMPLE/PRELOAD, 111 BYPASS. The reserved codes 011, 101 and 110 behave exactly like BYPASS on the data path.
- R6: Under IDCODE, Capture-DR loads the identity word, which is shifted out LSB first. The word has bit 0 = 1, bits [11:1] = manufacturer code 11'b000_0011_0011, bits [28:12] = 17-bit device code (default 17'h00254) and bits [31:29] = 000.
- R7: Under BYPASS, Capture-DR clears the bypass stage to 0. Each TDI bit then appears on `tdo` one shift later, so the first bit out is 0.
- R8: Under EXTEST, SAMPLE-Z or SAMPLE/PRELOAD, Capture-DR loads `pin_in` into the 107-bit chain, and it is shifted out with bit 0 first. A TDI bit reaches `tdo` after exactly 107 shifts.
- R9: On the falling TCK edge in Update-DR, under EXTEST, SAMPLE-Z or SAMPLE/PRELOAD, the chain's shift stage is copied to `pin_out`. Under any other instruction, `pin_out` is left unchanged.
- R10: `data_hiz` is 1 exactly while SAMPLE-Z is the active instruction. In particular, it stays 0 under SAMPLE/PRELOAD.
- R11: `extest_sel` is 1 exactly while EXTEST is the active instruction.
- R12: `tdo` and `tdo_oe` change only on falling TCK edges. `tdo_oe` is 1 only while the controller is in Shift-IR or Shift-DR.
- R13: A new instruction takes effect on the falling TCK edge in Update-IR. Bits that sit in the shift stage during Shift-IR or Pause-IR do not change the active instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| tms | input | 1 | Test mode select, sampled on rising TCK |
| tdi | input | 1 | Serial test data in, sampled on rising TCK |
| pin_in | input | BSR_LEN (107) | Sampled pad levels offered to the boundary chain |
| tdo | output | 1 | Serial test data out, updated on falling TCK |
| tdo_oe | output | 1 | Output enable for `tdo`; low means high impedance |
| pin_out | output | BSR_LEN (107) | Update stage of the boundary chain, driven toward the pads |
| data_hiz | output | 1 | Request to float the data outputs (SAMPLE-Z) |
| extest_sel | output | 1 | Pads take values from the chain instead of the functional path |

## Verification
Two things happen on the same falling TCK edge in Update-IR. A new instruction is committed, and that commit also moves `data_hiz`/`extest_sel` and re-routes which data register sits between TDI and TDO. The bench loads SAMPLE-Z and parks in Pause-IR with the opcode already in the shift stage. It confirms that `data_hiz` has not moved, then finishes the update and confirms the request rises. Straight afterwards, a 110-bit chain scan shows that the new path is in effect from the next Capture-DR: the sampled pins come out first, followed by the TDI bits delayed by exactly 107 shifts.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

  typedef enum logic [3:0] {
    ST_RESET,
    ST_IDLE,
    ST_DR_SEL,
    ST_DR_CAP,
    ST_DR_SHIFT,
    ST_DR_EX1,
    ST_DR_PAUSE,
    ST_DR_EX2,
    ST_DR_UPD,
    ST_IR_SEL,
    ST_IR_CAP,
    ST_IR_SHIFT,
    ST_IR_EX1,
    ST_IR_PAUSE,
    ST_IR_EX2,
    ST_IR_UPD
  } tap_state_e;

  typedef enum logic [1:0] {
    PATH_CHAIN,
    PATH_IDENT,
    PATH_BYPASS
  } dr_path_e;

  localparam int IR_W = 3;

  localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
  localparam logic [IR_W-1:0] OP_IDCODE  = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPZ   = 3'b010;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 3'b100;
  localparam logic [IR_W-1:0] OP_BYPASS  = 3'b111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import scan_tap_pkg::*;
(
  input  logic       tck,
  input  logic       por_n,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e nxt;

  always_comb begin
    case (state)
      ST_RESET:    nxt = tms ? ST_RESET    : ST_IDLE;
      ST_IDLE:     nxt = tms ? ST_DR_SEL   : ST_IDLE;
      ST_DR_SEL:   nxt = tms ? ST_IR_SEL   : ST_DR_CAP;
      ST_DR_CAP:   nxt = tms ? ST_DR_EX1   : ST_DR_SHIFT;
      ST_DR_SHIFT: nxt = tms ? ST_DR_EX1   : ST_DR_SHIFT;
      ST_DR_EX1:   nxt = tms ? ST_DR_UPD   : ST_DR_PAUSE;
      ST_DR_PAUSE: nxt = tms ? ST_DR_EX2   : ST_DR_PAUSE;
      ST_DR_EX2:   nxt = tms ? ST_DR_UPD   : ST_DR_SHIFT;
      ST_DR_UPD:   nxt = tms ? ST_DR_SEL   : ST_IDLE;
      ST_IR_SEL:   nxt = tms ? ST_RESET    : ST_IR_CAP;
      ST_IR_CAP:   nxt = tms ? ST_IR_EX1   : ST_IR_SHIFT;
      ST_IR_SHIFT: nxt = tms ? ST_IR_EX1   : ST_IR_SHIFT;
      ST_IR_EX1:   nxt = tms ? ST_IR_UPD   : ST_IR_PAUSE;
      ST_IR_PAUSE: nxt = tms ? ST_IR_EX2   : ST_IR_PAUSE;
      ST_IR_EX2:   nxt = tms ? ST_IR_UPD   : ST_IR_SHIFT;
      ST_IR_UPD:   nxt = tms ? ST_DR_SEL   : ST_IDLE;
      default:     nxt = ST_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) state <= ST_RESET;
    else        state <= nxt;
  end

  // R2
  reset_sticky_chk: assert property (@(posedge tck) disable iff (!por_n)
    (state == ST_RESET && tms) |=> state == ST_RESET);

  // R3
  pause_hold_chk: assert property (@(posedge tck) disable iff (!por_n)
    (state == ST_DR_PAUSE && !tms) |=> state == ST_DR_PAUSE);

endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import scan_tap_pkg::*;
(
  input  logic            tck,
  input  logic            por_n,
  input  tap_state_e      state,
  input  logic            tdi,
  output logic [IR_W-1:0] ir,
  output logic            ir_so,
  output dr_path_e        path,
  output logic            data_hiz,
  output logic            extest_sel
);

  logic [IR_W-1:0] ir_sh;

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n)                    ir_sh <= IR_CAPTURE;
    else if (state == ST_IR_CAP)   ir_sh <= IR_CAPTURE;
    else if (state == ST_IR_SHIFT) ir_sh <= {tdi, ir_sh[IR_W-1:1]};
  end

  always_ff @(negedge tck or negedge por_n) begin
    if (!por_n)                  ir <= OP_IDCODE;
    else if (state == ST_RESET)  ir <= OP_IDCODE;
    else if (state == ST_IR_UPD) ir <= ir_sh;
  end

  assign ir_so = ir_sh[0];

  always_comb begin
    path       = PATH_BYPASS;
    data_hiz   = 1'b0;
    extest_sel = 1'b0;
    case (ir)
      OP_EXTEST: begin path = PATH_CHAIN; extest_sel = 1'b1; end
      OP_IDCODE: path = PATH_IDENT;
      OP_SAMPZ:  begin path = PATH_CHAIN; data_hiz = 1'b1; end
      OP_SAMPLE: path = PATH_CHAIN;
      default:   path = PATH_BYPASS;
    endcase
  end

  // R13
  ir_commit_chk: assert property (@(posedge tck) disable iff (!por_n)
    !(state inside {ST_RESET, ST_IR_UPD}) |-> ir == $past(ir));

endmodule

// File: rtl/tap_idreg.sv
module tap_idreg #(
  parameter logic [2:0]  REV_CODE = 3'b000,
  parameter logic [16:0] DEV_CODE = 17'h00254,
  parameter logic [10:0] MFR_CODE = 11'b000_0011_0011
) (
  input  logic tck,
  input  logic por_n,
  input  logic cap_en,
  input  logic sh_en,
  input  logic tdi,
  output logic so
);

  localparam logic [31:0] ID_WORD = {REV_CODE, DEV_CODE, MFR_CODE, 1'b1};

  logic [31:0] q;

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n)      q <= ID_WORD;
    else if (cap_en) q <= ID_WORD;
    else if (sh_en)  q <= {tdi, q[31:1]};
  end

  assign so = q[0];

endmodule

// File: rtl/tap_bsr.sv
module tap_bsr #(
  parameter int LEN = 107
) (
  input  logic           tck,
  input  logic           por_n,
  input  logic           cap_en,
  input  logic           sh_en,
  input  logic           upd_en,
  input  logic           tdi,
  input  logic [LEN-1:0] pin_in,
  output logic           so,
  output logic [LEN-1:0] pin_out
);

  logic [LEN-1:0] cap_q;
  logic [LEN-1:0] upd_q;
  logic [LEN-1:0] shift_nxt;

  for (genvar i = 0; i < LEN; i++) begin : g_cell
    if (i == LEN - 1) begin : g_head
      assign shift_nxt[i] = tdi;
    end else begin : g_body
      assign shift_nxt[i] = cap_q[i+1];
    end
  end

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n)      cap_q <= '0;
    else if (cap_en) cap_q <= pin_in;
    else if (sh_en)  cap_q <= shift_nxt;
  end

  always_ff @(negedge tck or negedge por_n) begin
    if (!por_n)      upd_q <= '0;
    else if (upd_en) upd_q <= cap_q;
  end

  assign so      = cap_q[0];
  assign pin_out = upd_q;

  // R9
  update_hold_chk: assert property (@(posedge tck) disable iff (!por_n)
    !upd_en |-> upd_q == $past(upd_q));

endmodule

// File: rtl/scan_tap.sv
module scan_tap
  import scan_tap_pkg::*;
#(
  parameter int          BSR_LEN  = 107,
  parameter logic [16:0] DEV_CODE = 17'h00254,
  parameter logic [10:0] MFR_CODE = 11'b000_0011_0011
) (
  input  logic               tck,
  input  logic               por_n,
  input  logic               tms,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] pin_in,
  output logic               tdo,
  output logic               tdo_oe,
  output logic [BSR_LEN-1:0] pin_out,
  output logic               data_hiz,
  output logic               extest_sel
);

  tap_state_e      state;
  logic [IR_W-1:0] ir;
  logic            ir_so;
  dr_path_e        path;
  logic            id_so, bsr_so, byp_q;
  logic            dr_so;
  logic            cap_dr, sh_dr, upd_dr;
  logic            tdo_q, oe_q;

  tap_fsm u_fsm (
    .tck(tck), .por_n(por_n), .tms(tms), .state(state)
  );

  tap_ir u_ir (
    .tck(tck), .por_n(por_n), .state(state), .tdi(tdi),
    .ir(ir), .ir_so(ir_so), .path(path),
    .data_hiz(data_hiz), .extest_sel(extest_sel)
  );

  assign cap_dr = (state == ST_DR_CAP);
  assign sh_dr  = (state == ST_DR_SHIFT);
  assign upd_dr = (state == ST_DR_UPD);

  tap_idreg #(.DEV_CODE(DEV_CODE), .MFR_CODE(MFR_CODE)) u_id (
    .tck(tck), .por_n(por_n),
    .cap_en(cap_dr && path == PATH_IDENT),
    .sh_en(sh_dr && path == PATH_IDENT),
    .tdi(tdi), .so(id_so)
  );

  tap_bsr #(.LEN(BSR_LEN)) u_bsr (
    .tck(tck), .por_n(por_n),
    .cap_en(cap_dr && path == PATH_CHAIN),
    .sh_en(sh_dr && path == PATH_CHAIN),
    .upd_en(upd_dr && path == PATH_CHAIN),
    .tdi(tdi), .pin_in(pin_in), .so(bsr_so), .pin_out(pin_out)
  );

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n)                              byp_q <= 1'b0;
    else if (cap_dr && path == PATH_BYPASS)  byp_q <= 1'b0;
    else if (sh_dr && path == PATH_BYPASS)   byp_q <= tdi;
  end

  always_comb begin
    case (path)
      PATH_CHAIN: dr_so = bsr_so;
      PATH_IDENT: dr_so = id_so;
      default:    dr_so = byp_q;
    endcase
  end

  always_ff @(negedge tck or negedge por_n) begin
    if (!por_n) begin
      tdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      oe_q  <= (state == ST_IR_SHIFT) || (state == ST_DR_SHIFT);
      tdo_q <= (state == ST_IR_SHIFT) ? ir_so : dr_so;
    end
  end

  assign tdo    = tdo_q;
  assign tdo_oe = oe_q;

  // R12
  tdo_window_chk: assert property (@(posedge tck) disable iff (!por_n)
    tdo_oe |-> (state == ST_IR_SHIFT || state == ST_DR_SHIFT));

  // R10
  hiz_ext_excl_chk: assert property (@(posedge tck) disable iff (!por_n)
    !(data_hiz && extest_sel));

endmodule

// File: tb/scan_tap_test.sv
module scan_tap_test;

  localparam int N = 107;
  localparam logic [31:0] EXP_ID = {3'b000, 17'h00254, 11'b000_0011_0011, 1'b1};

  logic         tck = 1'b0;
  logic         por_n, tms, tdi;
  logic [N-1:0] pin_in;
  logic         tdo, tdo_oe, data_hiz, extest_sel;
  logic [N-1:0] pin_out;

  int n_run = 0, n_fail = 0;
  int edge_viol = 0, oe_bad = 0;
  logic last_oe;

  always #10 tck = ~tck;

  scan_tap uut (
    .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .pin_in(pin_in),
    .tdo(tdo), .tdo_oe(tdo_oe), .pin_out(pin_out),
    .data_hiz(data_hiz), .extest_sel(extest_sel)
  );

  task automatic check(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick(input logic m, input logic d, output logic o);
    @(negedge tck); #2;
    o = tdo; last_oe = tdo_oe;
    tms = m; tdi = d;
    @(posedge tck); #2;
    if (tdo !== o) edge_viol++;
  endtask

  task automatic scan_ir(input logic [2:0] op, output logic [2:0] cap);
    logic b;
    tick(1, 0, b); tick(1, 0, b); tick(0, 0, b); tick(0, 0, b);
    for (int i = 0; i < 3; i++) begin
      tick(i == 2, op[i], b);
      cap[i] = b;
      if (last_oe !== 1'b1) oe_bad++;
    end
    tick(1, 0, b); tick(0, 0, b);
  endtask

  task automatic scan_dr(input int n, input logic [127:0] din, output logic [127:0] dout);
    logic b;
    dout = '0;
    tick(1, 0, b); tick(0, 0, b); tick(0, 0, b);
    for (int i = 0; i < n; i++) begin
      tick(i == n - 1, din[i], b);
      dout[i] = b;
      if (last_oe !== 1'b1) oe_bad++;
    end
    tick(1, 0, b); tick(0, 0, b);
    @(negedge tck); #2;
  endtask

  task automatic t_reset;
    logic b;
    tms = 1; tdi = 1; por_n = 0; pin_in = '0;
    #25;
    check("R1", "tdo_oe in reset", 128'(tdo_oe), 128'(0));
    check("R1", "data_hiz in reset", 128'(data_hiz), 128'(0));
    check("R1", "extest_sel in reset", 128'(extest_sel), 128'(0));
    check("R1", "pin_out in reset", 128'(pin_out), 128'(0));
    @(negedge tck); #2; por_n = 1;
    for (int i = 0; i < 3; i++) tick(1, 1, b);
    check("R12", "tdo_oe idle in reset state", 128'(last_oe), 128'(0));
    tick(0, 1, b);
  endtask

  task automatic t_idcode;
    logic [127:0] d;
    scan_dr(32, '0, d);
    check("R6", "identity word after reset", d[31:0], 128'(EXP_ID));
    check("R12", "tdo_oe during shifts", 128'(oe_bad), 128'(0));
  endtask

  task automatic t_ir_capture;
    logic [2:0] c;
    logic [127:0] d;
    scan_ir(3'b111, c);
    check("R4", "Capture-IR pattern", 128'(c), 128'(3'b001));
    scan_dr(8, 128'hB2, d);
    check("R7", "bypass one-bit delay", d[7:0], 128'({8'hB2} << 1) & 128'hFF);
    check("R11", "extest_sel under BYPASS", 128'(extest_sel), 128'(0));
  endtask

  task automatic t_reserved;
    logic [2:0] c;
    logic [127:0] d;
    scan_ir(3'b011, c);
    scan_dr(5, 128'h17, d);
    check("R5", "reserved 011 acts as bypass", d[4:0], 128'h0E);
    scan_ir(3'b110, c);
    scan_dr(6, 128'h2D, d);
    check("R5", "reserved 110 acts as bypass", d[5:0], 128'h1A);
    check("R10", "data_hiz under reserved", 128'(data_hiz), 128'(0));
  endtask

  task automatic t_samplez_commit;
    logic b;
    logic [127:0] pat, din, d;
    pat = {32'hA5C3_96E1, 32'h1234_F0F0, 32'h0F1E_2D3C, 32'hDEAD_BEEF};
    pin_in = pat[N-1:0];
    din = {32'h0, 32'h5A5A_3C3C, 32'h8765_4321, 32'hC001_D00D};
    tick(1, 0, b); tick(1, 0, b); tick(0, 0, b); tick(0, 0, b);
    tick(0, 0, b); tick(0, 1, b); tick(1, 0, b);
    tick(0, 0, b); tick(0, 0, b);
    @(negedge tck); #2;
    check("R13", "data_hiz before Update-IR", 128'(data_hiz), 128'(0));
    check("R3", "Pause-IR holds, tdo_oe low", 128'(tdo_oe), 128'(0));
    tick(1, 0, b); tick(1, 0, b); tick(0, 0, b);
    @(negedge tck); #2;
    check("R13", "data_hiz after Update-IR", 128'(data_hiz), 128'(1));
    check("R10", "extest_sel under SAMPLE-Z", 128'(extest_sel), 128'(0));
    scan_dr(N + 3, din, d);
    check("R8", "captured pins", 128'(d[N-1:0]), 128'(pat[N-1:0]));
    check("R8", "TDI after 107 shifts", 128'(d[N+2:N]), 128'(din[2:0]));
    check("R9", "pin_out after Update-DR", 128'(pin_out), 128'(din[N+2:3]));
  endtask

  task automatic t_sample_extest;
    logic [2:0] c;
    logic [127:0] d, keep;
    scan_ir(3'b100, c);
    check("R10", "data_hiz under SAMPLE/PRELOAD", 128'(data_hiz), 128'(0));
    scan_ir(3'b000, c);
    check("R11", "extest_sel under EXTEST", 128'(extest_sel), 128'(1));
    check("R10", "data_hiz under EXTEST", 128'(data_hiz), 128'(0));
    keep = 128'(pin_out);
    scan_ir(3'b001, c);
    check("R11", "extest_sel under IDCODE", 128'(extest_sel), 128'(0));
    scan_dr(32, 128'hFFFF_FFFF, d);
    check("R9", "pin_out kept under IDCODE", 128'(pin_out), keep);
    check("R6", "identity word via opcode 001", d[31:0], 128'(EXP_ID));
  endtask

  task automatic t_tms_reset;
    logic [2:0] c;
    logic b;
    logic [127:0] d;
    scan_ir(3'b000, c);
    tick(1, 0, b); tick(0, 0, b); tick(0, 0, b);
    for (int i = 0; i < 5; i++) tick(1, 0, b);
    @(negedge tck); #2;
    check("R2", "extest_sel after five TMS=1", 128'(extest_sel), 128'(0));
    tick(0, 0, b);
    scan_dr(32, '0, d);
    check("R2", "IDCODE active after TMS reset", d[31:0], 128'(EXP_ID));
    check("R12", "tdo only moves on falling edge", 128'(edge_viol), 128'(0));
  endtask

  initial begin
    #3_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_idcode();
    t_ir_capture();
    t_reserved();
    t_samplez_commit();
    t_sample_extest();
    t_tms_reset();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule